// File: doc/BRIEF.md
# Page-Mode Pseudo-Static RAM Access Controller

This block sits between a synchronous on-chip requester and an asynchronous 16-bit pseudo-static RAM that supports fast in-page reads. A requester hands over one access at a time through a valid/ready handshake. Each access carries an address, write data, two byte enables, a read/write select and a burst flag. The controller drives the chip-enable, output-enable, write-enable, lower/upper byte strobes, the address bus and the write data. It returns read words with a one-cycle response pulse. Every analog timing limit of the memory is expressed as a whole number of controller clocks through parameters.

A read with the burst flag set leaves the chip selected after its word returns, and the page is held open. A later read that falls in the same eight-word page then changes only address bits [2:0] and completes in the short page cycle. The page is closed, with chip-enable high for a minimum gap, in four cases: the burst flag was clear on the last read, the next access hits another page, the next access is a write, or the open page approaches the longest time chip-enable may stay low. The next read after a close is a full random access. Writes always start from the deselected state with output-enable already high, so the memory never mistakes a write for a read.

Top module: `psram_page_ctrl`

## Requirements
- R1: During and right after reset, chip-enable, output-enable, write-enable and both byte strobes are high, the data bus driver is off, rsp_valid is low and req_ready is high.
- R2: A read accepted while the chip is deselected pulls chip-enable, output-enable and both byte strobes low and returns the whole word at the address. rsp_valid rises exactly T_RC clocks after the accepting edge. The byte enables of a read have no effect on the returned word.
- R3: A read accepted while a page is open, with address bits [20:3] equal to those of the open page, keeps chip-enable low and leaves address bits [20:3] unchanged. Its word is returned max(T_PAA, T_PRC) clocks after the accepting edge.
- R4: A page closes when the last read had its burst flag clear, or when a write or a read to another page is presented. Chip-enable then stays high for at least T_CP clocks, and the next read takes the full random time of R2.
- R5: Chip-enable is never low for T_PAGE_MAX consecutive clocks. A burst that would exceed this limit is closed, and its next read restarts as a random access.
- R6: Output-enable is high in every clock where write-enable and chip-enable are both low. Each write pulse, with chip-enable and write-enable low together, lasts at least T_WP clocks.
- R7: Byte enable bit 0 drives the lower strobe low, which writes data bits [7:0]. Byte enable bit 1 drives the upper strobe low, which writes bits [15:8]. A byte lane whose enable is clear keeps its old contents.
- R8: A write ends with chip-enable rising first. Write-enable stays low for T_WR more clocks after chip-enable rises.
- R9: A request is taken only on an edge with req_valid and req_ready both high. req_ready is low while a page is open and the presented request is a write or targets another page. rsp_valid is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Read: keep the page open after this word |
| req_be | input | 2 | Byte enables, bit 0 = bits [7:0], bit 1 = bits [15:8] |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read word valid, one-cycle pulse |
| rsp_rdata | output | DATA_W | Read word |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The forced close of a long burst is the hardest case to reach from the ports, because it needs a sustained run of in-page reads. The bench reaches it by shrinking the wall-clock limit to 60 clocks. It then keeps presenting same-page burst reads until one of them comes back with random-access latency. The bench memory model also returns a poison word whenever the random or page access age is too short, so any shortened timing shows up as bad data.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_RAND   = 3'd1,
        ST_PAGE_OPEN = 3'd2,
        ST_RD_PAGE   = 3'd3,
        ST_WR_PULSE  = 3'd4,
        ST_WR_END    = 3'd5,
        ST_GAP       = 3'd6
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic lb_n;
        logic ub_n;
        logic dq_oe;
    } pin_lvl_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to a controller phase.
    function automatic pin_lvl_t pins_for(input ctrl_state_e st, input logic [1:0] be);
        pin_lvl_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_RD_RAND, ST_PAGE_OPEN, ST_RD_PAGE: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
                p.lb_n = 1'b0;
                p.ub_n = 1'b0;
            end
            ST_WR_PULSE: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.lb_n  = ~be[0];
                p.ub_n  = ~be[1];
                p.dq_oe = 1'b1;
            end
            ST_WR_END: begin
                p.we_n  = 1'b0;
                p.lb_n  = ~be[0];
                p.ub_n  = ~be[1];
                p.dq_oe = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
`timescale 1ns/1ps
module psram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] span,
    output logic          last
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {TW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == span - 1'b1);
endmodule

// File: rtl/psram_page_guard.sv
`timescale 1ns/1ps
module psram_page_guard #(
    parameter int TAG_W      = 18,
    parameter int WW         = 10,
    parameter int WALL_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_start,
    input  logic             ce_low,
    input  logic [TAG_W-1:0] new_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             page_hit,
    output logic             wall_expired
);
    logic [TAG_W-1:0] tag_q;
    logic [WW-1:0]    wall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            wall_q <= '0;
        end else if (open_start) begin
            tag_q  <= new_tag;
            wall_q <= '0;
        end else if (ce_low && wall_q != {WW{1'b1}}) begin
            wall_q <= wall_q + 1'b1;
        end
    end

    assign page_hit     = (req_tag == tag_q);
    assign wall_expired = (wall_q >= WW'(WALL_LIMIT));
endmodule

// File: rtl/psram_pin_driver.sv
`timescale 1ns/1ps
module psram_pin_driver
    import psram_ctrl_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_lvl_t      lvl_d,
    input  logic [AW-1:0] addr_d,
    input  logic [DW-1:0] wdata_d,
    output pin_lvl_t      lvl_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1, dq_oe: 1'b0};
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            lvl_q   <= lvl_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end
endmodule

// File: rtl/psram_page_ctrl.sv
`timescale 1ns/1ps
module psram_page_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 16,
    parameter int PAGE_BITS  = 3,
    parameter int T_RC       = 13,
    parameter int T_PAA      = 4,
    parameter int T_PRC      = 5,
    parameter int T_WP       = 8,
    parameter int T_WR       = 3,
    parameter int T_CP       = 3,
    parameter int T_PAGE_MAX = 800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PG_CYC     = max_i(T_PAA, T_PRC);
    localparam int WR_LEN     = (T_RC > T_WR + T_WP) ? (T_RC - T_WR) : T_WP;
    localparam int SPAN_MAX   = max_i(max_i(T_RC, PG_CYC), max_i(max_i(WR_LEN, T_WR), T_CP));
    localparam int TW         = $clog2(SPAN_MAX + 1);
    localparam int WW         = $clog2(T_PAGE_MAX + 1);
    localparam int WALL_LIMIT = T_PAGE_MAX - PG_CYC - 3;
    localparam int TAG_W      = ADDR_W - PAGE_BITS;
    localparam int HW         = $clog2(T_CP + 2);

    ctrl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;
    logic [1:0]        be_q, be_d;
    logic              burst_q, burst_d;
    logic              capture;
    logic              tag_load;
    logic              phase_last;
    logic              page_hit;
    logic              wall_expired;
    logic [TW-1:0]     span;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rdata_q;
    pin_lvl_t          lvl_d, lvl_q;
    logic [ADDR_W-1:0] pin_addr;
    logic [DATA_W-1:0] pin_wdata;

    // Phase length of the current state.
    always_comb begin
        case (state_q)
            ST_RD_RAND:  span = TW'(T_RC);
            ST_RD_PAGE:  span = TW'(PG_CYC);
            ST_WR_PULSE: span = TW'(WR_LEN);
            ST_WR_END:   span = TW'(T_WR);
            ST_GAP:      span = TW'(T_CP);
            default:     span = TW'(1);
        endcase
    end

    psram_phase_timer #(.TW(TW)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .restart (state_d != state_q),
        .span    (span),
        .last    (phase_last)
    );

    psram_page_guard #(.TAG_W(TAG_W), .WW(WW), .WALL_LIMIT(WALL_LIMIT)) guard_i (
        .clk          (clk),
        .rst          (rst),
        .open_start   (tag_load),
        .ce_low       (state_q == ST_RD_RAND || state_q == ST_PAGE_OPEN || state_q == ST_RD_PAGE),
        .new_tag      (req_addr[ADDR_W-1:PAGE_BITS]),
        .req_tag      (req_addr[ADDR_W-1:PAGE_BITS]),
        .page_hit     (page_hit),
        .wall_expired (wall_expired)
    );

    // Sequencer.
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        wdata_d   = wdata_q;
        be_d      = be_q;
        burst_d   = burst_q;
        req_ready = 1'b0;
        capture   = 1'b0;
        tag_load  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    addr_d   = req_addr;
                    wdata_d  = req_wdata;
                    be_d     = req_be;
                    burst_d  = req_burst & ~req_write;
                    tag_load = ~req_write;
                    state_d  = req_write ? ST_WR_PULSE : ST_RD_RAND;
                end
            end
            ST_RD_RAND, ST_RD_PAGE: begin
                if (phase_last) begin
                    capture = 1'b1;
                    state_d = burst_q ? ST_PAGE_OPEN : ST_GAP;
                end
            end
            ST_PAGE_OPEN: begin
                req_ready = ~req_write & page_hit & ~wall_expired;
                if (req_valid && req_ready) begin
                    addr_d  = req_addr;
                    burst_d = req_burst;
                    state_d = ST_RD_PAGE;
                end else if (req_valid || wall_expired) begin
                    state_d = ST_GAP;
                end
            end
            ST_WR_PULSE: if (phase_last) state_d = ST_WR_END;
            ST_WR_END:   if (phase_last) state_d = ST_GAP;
            ST_GAP:      if (phase_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
            burst_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            state_q     <= state_d;
            addr_q      <= addr_d;
            wdata_q     <= wdata_d;
            be_q        <= be_d;
            burst_q     <= burst_d;
            rsp_valid_q <= capture;
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign lvl_d = pins_for(state_d, be_d);

    psram_pin_driver #(.AW(ADDR_W), .DW(DATA_W)) pins_i (
        .clk     (clk),
        .rst     (rst),
        .lvl_d   (lvl_d),
        .addr_d  (addr_d),
        .wdata_d (wdata_d),
        .lvl_q   (lvl_q),
        .addr_q  (pin_addr),
        .wdata_q (pin_wdata)
    );

    assign mem_ce_n   = lvl_q.ce_n;
    assign mem_oe_n   = lvl_q.oe_n;
    assign mem_we_n   = lvl_q.we_n;
    assign mem_lb_n   = lvl_q.lb_n;
    assign mem_ub_n   = lvl_q.ub_n;
    assign mem_dq_oe  = lvl_q.dq_oe;
    assign mem_addr   = pin_addr;
    assign mem_dq_out = pin_wdata;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rdata_q;

    // Pin-level run counters for the timing properties.
    logic [HW-1:0] hi_run;
    logic [WW-1:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= HW'(T_CP);
            lo_run <= '0;
        end else begin
            if (mem_ce_n) begin
                lo_run <= '0;
                if (hi_run != {HW{1'b1}}) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
                if (lo_run != {WW{1'b1}}) lo_run <= lo_run + 1'b1;
            end
        end
    end

    p_ce_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (hi_run >= HW'(T_CP)));

    p_wall_limit_r5: assert property (@(posedge clk) disable iff (rst)
        lo_run < WW'(T_PAGE_MAX));

    p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !mem_ce_n) |-> mem_oe_n);

    p_ce_before_we_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> $past(mem_ce_n));

    p_page_upper_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |->
        (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS])));

    p_rsp_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/psram_page_ctrl_tb.sv
`timescale 1ns/1ps
module psram_page_ctrl_tb_top;
    localparam int T_RC   = 13;
    localparam int T_PAA  = 4;
    localparam int T_PRC  = 5;
    localparam int T_WP   = 8;
    localparam int T_WR   = 3;
    localparam int T_CP   = 3;
    localparam int T_PMAX = 60;
    localparam int PG     = (T_PAA > T_PRC) ? T_PAA : T_PRC;
    localparam int NV     = 15;

    // {write, burst, be[1:0], addr[20:0], wdata[15:0]}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'b00, 21'h00010, 16'h0000},
        {1'b1, 1'b0, 2'b11, 21'h00020, 16'h1234},
        {1'b0, 1'b0, 2'b11, 21'h00020, 16'h0000},
        {1'b0, 1'b1, 2'b11, 21'h1A048, 16'h0000},
        {1'b0, 1'b1, 2'b11, 21'h1A04B, 16'h0000},
        {1'b0, 1'b1, 2'b11, 21'h1A04F, 16'h0000},
        {1'b0, 1'b0, 2'b11, 21'h1A049, 16'h0000},
        {1'b1, 1'b0, 2'b01, 21'h00031, 16'hABCD},
        {1'b0, 1'b1, 2'b11, 21'h00031, 16'h0000},
        {1'b0, 1'b1, 2'b11, 21'h00035, 16'h0000},
        {1'b0, 1'b1, 2'b11, 21'h10035, 16'h0000},
        {1'b1, 1'b0, 2'b10, 21'h00035, 16'h7700},
        {1'b0, 1'b0, 2'b11, 21'h00035, 16'h0000},
        {1'b0, 1'b0, 2'b11, 21'h00060, 16'h0000},
        {1'b0, 1'b0, 2'b11, 21'h00061, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [20:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psram_page_ctrl #(
        .T_RC(T_RC), .T_PAA(T_PAA), .T_PRC(T_PRC), .T_WP(T_WP),
        .T_WR(T_WR), .T_CP(T_CP), .T_PAGE_MAX(T_PMAX)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_be(req_be),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Device model and pin monitors, sampled on falling edges.
    logic [15:0] dev_mem [256];
    logic [15:0] ref_mem [256];
    int rnd_age = 0, pg_age = 0, wp_cnt = 0, rec_cnt = 0, hi_cnt = 100, lo_cnt = 0;
    logic [20:0] prev_addr = '0;
    bit oe_bad = 1'b0;
    bit prev_ce_n = 1'b1;

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
            ref_mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ce_n) begin
                rnd_age = 0;
                pg_age  = 0;
            end else begin
                rnd_age++;
                pg_age = (mem_addr != prev_addr) ? 1 : pg_age + 1;
            end
            prev_addr = mem_addr;
            mem_dq_in = (!mem_ce_n && !mem_oe_n && rnd_age >= T_RC && pg_age >= T_PAA)
                        ? dev_mem[mem_addr[7:0]] : 16'hBAD0;
            // write pulse tracking (R6, R7, R8)
            if (!mem_ce_n && !mem_we_n) begin
                wp_cnt++;
                if (!mem_oe_n) oe_bad = 1'b1;
            end else if (wp_cnt > 0) begin
                chk(wp_cnt >= T_WP, "R6 write pulse length", wp_cnt, T_WP);
                chk(!oe_bad, "R6 output-enable high while writing", oe_bad, 0);
                chk(mem_ce_n, "R8 chip-enable rises first", mem_ce_n, 1);
                if (mem_dq_oe && !mem_lb_n) dev_mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
                if (mem_dq_oe && !mem_ub_n) dev_mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
                wp_cnt = 0;
                oe_bad = 1'b0;
            end
            if (mem_ce_n && !mem_we_n) rec_cnt++;
            else if (mem_we_n && rec_cnt > 0) begin
                chk(rec_cnt >= T_WR, "R8 write-enable low after chip-enable rise", rec_cnt, T_WR);
                rec_cnt = 0;
            end
            // chip-enable run lengths (R4, R5)
            if (prev_ce_n && !mem_ce_n) begin
                chk(hi_cnt >= T_CP, "R4 chip-enable high gap", hi_cnt, T_CP);
            end
            if (!prev_ce_n && mem_ce_n) begin
                chk(lo_cnt < T_PMAX, "R5 chip-enable low run", lo_cnt, T_PMAX);
            end
            if (mem_ce_n) begin hi_cnt++; lo_cnt = 0; end
            else begin lo_cnt++; hi_cnt = 0; end
            prev_ce_n = mem_ce_n;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_req(input bit wr, input bit bt, input logic [1:0] be,
                          input logic [20:0] a, input logic [15:0] wd,
                          output int lat, output logic [15:0] rd);
        req_valid = 1'b1;
        req_write = wr;
        req_burst = bt;
        req_be    = be;
        req_addr  = a;
        req_wdata = wd;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rd  = '0;
        if (!wr) begin
            while (!rsp_valid) begin
                @(negedge clk);
                lat++;
            end
            rd = rsp_rdata;
        end
    endtask

    task automatic ref_write(input logic [1:0] be, input logic [20:0] a, input logic [15:0] wd);
        if (be[0]) ref_mem[a[7:0]][7:0]  = wd[7:0];
        if (be[1]) ref_mem[a[7:0]][15:8] = wd[15:8];
    endtask

    initial begin
        int lat;
        logic [15:0] rd;
        bit open;
        logic [17:0] open_tag, last_tag;
        bit saw_restart;
        open = 1'b0;
        open_tag = '0;
        last_tag = '1;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 control strobes high in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_lb_n && mem_ub_n && !mem_dq_oe, "R1 byte strobes high, driver off",
            {mem_lb_n, mem_ub_n, mem_dq_oe}, 3'b110);
        chk(!rsp_valid && req_ready, "R1 handshake idle", {rsp_valid, req_ready}, 2'b01);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            bit          v_wr, v_bt, hit;
            logic [1:0]  v_be;
            logic [20:0] v_a;
            logic [15:0] v_wd;
            string       tag;
            {v_wr, v_bt, v_be, v_a, v_wd} = VEC[i];
            if (v_wr) begin
                do_req(1'b1, 1'b0, v_be, v_a, v_wd, lat, rd);
                ref_write(v_be, v_a, v_wd);
                open = 1'b0;
            end else begin
                hit = open && (open_tag == v_a[20:3]);
                if (hit) tag = "R3";
                else if (last_tag == v_a[20:3]) tag = "R4";
                else tag = "R2";
                do_req(1'b0, v_bt, v_be, v_a, 16'h0, lat, rd);
                chk(lat == (hit ? PG + 1 : T_RC + 1), {tag, " read latency"}, lat,
                    hit ? PG + 1 : T_RC + 1);
                chk(rd == ref_mem[v_a[7:0]], (i == 8 || i == 12) ? "R7 byte lane contents" :
                    {tag, " read data"}, rd, ref_mem[v_a[7:0]]);
                open     = v_bt;
                open_tag = v_a[20:3];
                last_tag = v_a[20:3];
            end
        end

        // R9: write presented while a page is open is held off
        do_req(1'b0, 1'b1, 2'b11, 21'h00050, 16'h0, lat, rd);
        chk(rd == ref_mem[8'h50], "R2 read before held-off write", rd, ref_mem[8'h50]);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_be    = 2'b11;
        req_addr  = 21'h00051;
        req_wdata = 16'h5EED;
        #1;
        chk(!req_ready, "R9 ready low for write on open page", req_ready, 0);
        do_req(1'b1, 1'b0, 2'b11, 21'h00051, 16'h5EED, lat, rd);
        ref_write(2'b11, 21'h00051, 16'h5EED);
        do_req(1'b0, 1'b0, 2'b11, 21'h00051, 16'h0, lat, rd);
        chk(rd == 16'h5EED, "R6 word write read back", rd, 16'h5EED);
        chk(lat == T_RC + 1, "R4 random read after write", lat, T_RC + 1);

        // R5: long burst is force-closed and restarts as a random read
        saw_restart = 1'b0;
        do_req(1'b0, 1'b1, 2'b11, 21'h00040, 16'h0, lat, rd);
        for (int k = 1; k < 15; k++) begin
            logic [20:0] a;
            a = 21'h00040 + 21'(k % 8);
            do_req(1'b0, 1'b1, 2'b11, a, 16'h0, lat, rd);
            if (rd != ref_mem[a[7:0]])
                chk(1'b0, "R5 data within long burst", rd, ref_mem[a[7:0]]);
            if (lat == T_RC + 1) saw_restart = 1'b1;
        end
        chk(saw_restart, "R5 forced close and random restart", saw_restart, 1);
        do_req(1'b0, 1'b0, 2'b11, 21'h00041, 16'h0, lat, rd);
        chk(rd == ref_mem[8'h41], "R3 burst closing read", rd, ref_mem[8'h41]);
        repeat (T_CP + 4) @(negedge clk);
        chk(mem_ce_n, "R4 chip deselected after close", mem_ce_n, 1);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule